// File: doc/BRIEF.md
# Two-Counter Pulse-Width Modulator

This block produces a pulse-width modulated signal from two down-counting timers that share one clock. The period timer sets the length of each cycle and the duty timer sets how long the output stays high at its start. Software sets the two load values and an enable bit through a plain register-write port. The block drives one output pin.

Load values are first held in staging registers. They move into the timers only when a new period begins, so a period that has already started always finishes with the values it began with. The cycle count comes out two cycles longer than each load value. Because of that, the shortest high pulse is two cycles and the output can never be high for a whole period. A duty load that is not below the period load gives a fully low output rather than a fully high one.

Top module: `pwm_dual_timer`

## Requirements
- R1: After reset the output is low, the enable bit is clear and both load values are zero. With zero loads, setting enable alone keeps the output low.
- R2: While enabled, each output period lasts exactly the period load plus 2 clock cycles.
- R3: When the duty load is below the period load, the output rises at the start of every period and stays high for exactly the duty load plus 2 cycles. It is low for the rest of the period.
- R4: When the duty load is equal to or greater than the period load, the output stays low for every period.
- R5: The smallest settings work: a period load of 1 with a duty load of 0 gives a 3-cycle period that is high for 2 cycles. A duty load one below the period load leaves exactly one low cycle.
- R6: Load values written during a period do not change that period. They apply from the next period start.
- R7: Clearing the enable bit drives the output low by the second clock edge after the write, and the output stays low while disabled. Setting the enable bit starts a fresh period, with the output rising on the second clock edge after the write.
- R8: Register select 0 writes the period load, 1 writes the duty load, and 2 writes the enable from data bit 0. A write with select 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 period, 1 duty, 2 enable, 3 unused) |
| wr_data | input | 32 | Write data |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The assertions assume that reset is held for at least one clock edge before anything else happens, and that write strobes last only one cycle. They make no assumption about when a write lands relative to a period start. The stimulus writes new loads at known points in a running period to exercise the staging rule. It also keeps the load values small enough that every period in the run finishes within a few hundred cycles.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_PERIOD = 2'd0,
    SEL_DUTY   = 2'd1,
    SEL_ENABLE = 2'd2,
    SEL_SPARE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pwm_stage_regs.sv
module pwm_stage_regs
  import pwm_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    per_load,
  output logic [DW-1:0]    duty_load,
  output logic             enable
);

  always_ff @(posedge clk) begin
    if (rst) begin
      per_load  <= '0;
      duty_load <= '0;
      enable    <= 1'b0;
    end else if (wr_en) begin
      case (reg_sel_e'(wr_sel))
        SEL_PERIOD: per_load  <= wr_data;
        SEL_DUTY:   duty_load <= wr_data;
        SEL_ENABLE: enable    <= wr_data[0];
        default: ;
      endcase
    end
  end

  // R8
  spare_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_SPARE) |=> ($stable(per_load) && $stable(duty_load) && $stable(enable)));

endmodule

// File: rtl/pwm_down_timer.sv
module pwm_down_timer #(
  parameter int CW = 33
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          load,
  input  logic [CW-1:0] reload,
  output logic [CW-1:0] count,
  output logic          at_zero
);

  always_ff @(posedge clk) begin
    if (rst)               count <= '0;
    else if (!run || load) count <= reload;
    else if (count != '0)  count <= count - CW'(1);
  end

  assign at_zero = (count == '0);

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !load && count != '0) |=> (count == $past(count) - CW'(1)));

  // R7
  park_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (count == $past(reload)));

endmodule

// File: rtl/pwm_dual_timer.sv
module pwm_dual_timer
  import pwm_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [DW-1:0]    wr_data,
  output logic             pwm_out
);

  localparam int CW = DW + 1;

  logic [DW-1:0] per_load, duty_load;
  logic          en_q;
  logic [CW-1:0] per_count, duty_count;
  logic          per_zero, duty_zero;
  logic          started, boundary, pwm_q;
  logic [DW-1:0] act_per, act_duty;

  pwm_stage_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .per_load(per_load), .duty_load(duty_load), .enable(en_q)
  );

  assign boundary = en_q && (!started || per_zero);

  pwm_down_timer #(.CW(CW)) u_per_timer (
    .clk(clk), .rst(rst), .run(en_q), .load(boundary),
    .reload({1'b0, per_load} + CW'(1)),
    .count(per_count), .at_zero(per_zero)
  );

  pwm_down_timer #(.CW(CW)) u_duty_timer (
    .clk(clk), .rst(rst), .run(en_q), .load(boundary),
    .reload({1'b0, duty_load} + CW'(1)),
    .count(duty_count), .at_zero(duty_zero)
  );

  always_ff @(posedge clk) begin
    if (rst || !en_q) begin
      started <= 1'b0;
      pwm_q   <= 1'b0;
    end else begin
      started <= 1'b1;
      if (boundary) pwm_q <= (duty_load < per_load);
      else          pwm_q <= pwm_q && !duty_zero;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_per  <= '0;
      act_duty <= '0;
    end else if (boundary) begin
      act_per  <= per_load;
      act_duty <= duty_load;
    end
  end

  assign pwm_out = pwm_q;

  // R4
  no_high_when_full_chk: assert property (@(posedge clk) disable iff (rst)
    pwm_q |-> (act_duty < act_per));

  // R3
  rise_at_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pwm_q) |-> (per_count == {1'b0, act_per} + CW'(1)));

  // R5
  fall_on_expiry_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(pwm_q) && en_q && !boundary) |-> duty_zero);

  // R7
  off_low_chk: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !pwm_q);

endmodule

// File: tb/test_pwm_dual_timer.sv
module test_pwm_dual_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic        pwm_out;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  pwm_dual_timer i_pwm_dual_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .pwm_out(pwm_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called at a negedge; the write is captured at the next posedge
  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic sync_rise();
    logic prev;
    prev = pwm_out;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (pwm_out && !prev) return;
      prev = pwm_out;
    end
  endtask

  task automatic measure(input int h0, output int h, output int l);
    h = h0;
    l = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (!pwm_out) break;
      h++;
    end
    l = 1;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (pwm_out) break;
      l++;
    end
  endtask

  task automatic low_for(input int n, input string req);
    int highs;
    highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) highs++;
    end
    check(highs == 0, req, highs, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(pwm_out == 1'b0, "R1 output low after reset", pwm_out, 0);
    low_for(10, "R1 stays low while disabled");
    wr(2'd2, 32'd1);
    low_for(30, "R1 zero loads give low output");
  endtask

  task automatic t_basic();
    int h, l;
    wr(2'd0, 32'd9);
    wr(2'd1, 32'd3);
    sync_rise();
    for (int p = 0; p < 3; p++) begin
      measure(1, h, l);
      check(h == 5, "R3 high time duty+2", h, 5);
      check(h + l == 11, "R2 period load+2", h + l, 11);
    end
  endtask

  task automatic t_full();
    wr(2'd0, 32'd7);
    wr(2'd1, 32'd7);
    repeat (20) @(negedge clk);
    low_for(40, "R4 duty equal to period stays low");
    wr(2'd1, 32'd50);
    repeat (20) @(negedge clk);
    low_for(40, "R4 duty above period stays low");
  endtask

  task automatic t_min();
    int h, l;
    wr(2'd0, 32'd1);
    wr(2'd1, 32'd0);
    sync_rise();
    for (int p = 0; p < 3; p++) begin
      measure(1, h, l);
      check(h == 2, "R5 minimum high", h, 2);
      check(l == 1, "R5 minimum low", l, 1);
    end
    wr(2'd0, 32'd100);
    wr(2'd1, 32'd99);
    sync_rise();
    measure(1, h, l);
    check(h == 101, "R5 duty one below period high", h, 101);
    check(l == 1, "R5 duty one below period low", l, 1);
  endtask

  task automatic t_update();
    int h, l;
    wr(2'd0, 32'd9);
    wr(2'd1, 32'd3);
    sync_rise();
    sync_rise();
    wr(2'd0, 32'd5);
    wr(2'd1, 32'd1);
    measure(3, h, l);
    check(h == 5, "R6 current period keeps old high", h, 5);
    check(h + l == 11, "R6 current period keeps old length", h + l, 11);
    measure(1, h, l);
    check(h == 3, "R6 next period new high", h, 3);
    check(h + l == 7, "R6 next period new length", h + l, 7);
  endtask

  task automatic t_enable();
    int h, l;
    wr(2'd0, 32'd20);
    wr(2'd1, 32'd10);
    sync_rise();
    sync_rise();
    repeat (4) @(negedge clk);
    wr(2'd2, 32'd0);
    @(negedge clk);
    check(pwm_out == 1'b0, "R7 low after disable", pwm_out, 0);
    low_for(50, "R7 stays low while disabled");
    wr(2'd2, 32'd1);
    check(pwm_out == 1'b0, "R7 not yet high one edge after enable", pwm_out, 0);
    @(negedge clk);
    check(pwm_out == 1'b1, "R7 high two edges after enable", pwm_out, 1);
    measure(1, h, l);
    check(h == 12, "R7 fresh period high", h, 12);
    check(h + l == 22, "R7 fresh period length", h + l, 22);
  endtask

  task automatic t_spare();
    int h, l;
    wr(2'd3, 32'h0000_0003);
    wr(2'd3, 32'h0000_0000);
    sync_rise();
    measure(1, h, l);
    check(h == 12, "R8 spare select leaves duty", h, 12);
    check(h + l == 22, "R8 spare select leaves period and enable", h + l, 22);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_full();
    t_min();
    t_update();
    t_enable();
    t_spare();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule